// File: doc/BRIEF.md
# Two-Level Page-Table Refill Walker

This block services a translation miss. When a lookup finds no matching translation entry, the core pulses a start strobe with the faulting virtual address, the access kind (read or write) and the page-directory base pointer. The walker reads one directory word, then two neighbouring leaf entries (the even and odd page of a pair). It shifts each leaf right into translation-entry format, writes the pair into one slot of the translation buffer, and then judges the faulting access against the half it touched.

Pointers held in memory are kernel unmapped addresses. The walker removes the kernel base (0x80000000) from both the directory base and the second-level table pointer before using them. A zero directory base means that no table has been set up, so the walk ends at once with "no match". The slot to overwrite comes from a round-robin counter that steps once per translation-buffer write. The walker writes nothing outside its memory read port and its translation write port, so a finished walk leaves no other state changed.

Top module: `ptw_walker`

## Requirements
- R1: After reset the walker is idle: `busy_o`, `mem_req_o`, `tlb_we_o` and `done_o` are all 0.
- R2: A start accepted with `dir_base_i` equal to zero produces `done_o` with `result_o` = 3 (no match) on the next cycle. It issues no memory read and no translation write.
- R3: The first read goes to address `(dir_base - 0x80000000) + vaddr[31:22]*4`. The word it returns is taken as the table pointer.
- R4: The even leaf is read at `(table_ptr - 0x80000000) + vaddr[21:13]*8`, and the odd leaf is read next at that address plus 4.
- R5: `mem_req_o` stays high and `mem_addr_o` stays unchanged until the cycle in which `mem_ack_i` is high. Each read completes on that acknowledge.
- R6: After both reads, `tlb_we_o` pulses for exactly one cycle with `tlb_lo0_o` = even word >> 6, `tlb_lo1_o` = odd word >> 6 and `tlb_vpn2_o` = vaddr[31:13]. `done_o` follows in the next cycle.
- R7: The slot on `tlb_idx_o` is 0 for the first write after reset and advances by one after each write, wrapping from TLB_ENTRIES-1 to 0.
- R8: The faulting access uses the odd entry when vaddr[12] is 1 and the even entry otherwise. If bit 1 (valid) of that converted entry is 0, the result is 1 (invalid).
- R9: A write whose selected entry is valid but has bit 2 (dirty) clear gives result 2 (modify). A read of the same entry gives result 0 (match).
- R10: On a match, `paddr_o` = ((entry >> 6) << 12) | vaddr[11:0].
- R11: A start while `busy_o` is 1 is ignored. The walk in flight keeps its latched address, access kind and base, and no extra walk follows.
- R12: `done_o` is a single-cycle pulse, and the walker is idle again in the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin a walk (sampled only when idle) |
| vaddr_i | input | AW (32) | Faulting virtual address |
| is_write_i | input | 1 | 1 = store access, 0 = load |
| dir_base_i | input | AW (32) | Page-directory base pointer (kernel address) |
| busy_o | output | 1 | Walk in progress |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | AW (32) | Physical read address |
| mem_ack_i | input | 1 | Read acknowledge, data valid |
| mem_rdata_i | input | AW (32) | Read data |
| tlb_we_o | output | 1 | Translation entry write strobe |
| tlb_idx_o | output | clog2(TLB_ENTRIES) (4) | Slot being written |
| tlb_vpn2_o | output | AW-13 (19) | Virtual page-pair number |
| tlb_lo0_o | output | AW (32) | Converted even entry |
| tlb_lo1_o | output | AW (32) | Converted odd entry |
| done_o | output | 1 | Walk finished, result valid |
| result_o | output | 2 | 0 match, 1 invalid, 2 modify, 3 no match |
| paddr_o | output | AW (32) | Physical address on a match |

## Verification
The hardest case to reach is a start strobe that lands while a walk is still in flight. From outside, that strobe looks like an ordinary request. The bench raises start with a different address, access kind and a zero base on the very first cycle after a walk has been accepted, including during the one-cycle zero-base walk. It then checks that the first walk's results are unchanged and that no second result appears. The round-robin slot wrap is hard to reach because it needs more refills than there are slots. A loop of eighteen walks with varying acknowledge latency carries the counter past its wrap point.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    typedef enum logic [2:0] {
        S_IDLE  = 3'd0,
        S_DIR   = 3'd1,
        S_EVEN  = 3'd2,
        S_ODD   = 3'd3,
        S_WRITE = 3'd4,
        S_DONE  = 3'd5
    } walk_state_e;

    localparam logic [1:0] RES_MATCH   = 2'd0;
    localparam logic [1:0] RES_INVALID = 2'd1;
    localparam logic [1:0] RES_MODIFY  = 2'd2;
    localparam logic [1:0] RES_NOMATCH = 2'd3;

endpackage

// File: rtl/ptw_addr_gen.sv
// Address arithmetic for the two memory levels.
module ptw_addr_gen #(
    parameter int          AW       = 32,
    parameter logic [AW-1:0] KBASE  = 32'h8000_0000,
    parameter int          DIR_LSB  = 22,
    parameter int          PAIR_LSB = 13
) (
    input  logic [AW-1:0]          dir_base,
    input  logic [AW-1:0]          tbl_ptr,
    input  logic [AW-1:PAIR_LSB]   va_hi,
    output logic [AW-1:0]          dir_addr,
    output logic [AW-1:0]          even_addr,
    output logic [AW-1:0]          odd_addr
);
    localparam int DIR_W  = AW - DIR_LSB;
    localparam int PAIR_W = DIR_LSB - PAIR_LSB;

    logic [AW-1:0] dir_off;
    logic [AW-1:0] pair_off;

    always_comb begin
        dir_off   = {{(AW-DIR_W-2){1'b0}}, va_hi[AW-1:DIR_LSB], 2'b00};
        pair_off  = {{(AW-PAIR_W-3){1'b0}}, va_hi[DIR_LSB-1:PAIR_LSB], 3'b000};
        dir_addr  = (dir_base - KBASE) + dir_off;
        even_addr = (tbl_ptr - KBASE) + pair_off;
        odd_addr  = even_addr + AW'(4);
    end
endmodule

// File: rtl/ptw_entry_eval.sv
// Judges the faulting access against the selected half of the refilled pair.
module ptw_entry_eval #(
    parameter int AW         = 32,
    parameter int PTE_SHIFT  = 6,
    parameter int PAGE_SHIFT = 12,
    parameter int VALID_BIT  = 1,
    parameter int DIRTY_BIT  = 2
) (
    input  logic [AW-1:0]         lo_even,
    input  logic [AW-1:0]         lo_odd,
    input  logic                  odd_sel,
    input  logic [PAGE_SHIFT-1:0] page_off,
    input  logic                  is_write,
    output logic [1:0]            result,
    output logic [AW-1:0]         paddr
);
    import ptw_pkg::*;

    logic [AW-1:0] entry;
    logic [AW-1:0] frame;

    always_comb begin
        entry = odd_sel ? lo_odd : lo_even;
        frame = (entry >> PTE_SHIFT) << PAGE_SHIFT;
        paddr = frame | {{(AW-PAGE_SHIFT){1'b0}}, page_off};
        if (!entry[VALID_BIT]) begin
            result = RES_INVALID;
        end else if (is_write && !entry[DIRTY_BIT]) begin
            result = RES_MODIFY;
        end else begin
            result = RES_MATCH;
        end
    end
endmodule

// File: rtl/ptw_victim_ctr.sv
// Round-robin slot pointer, steps once per translation write.
module ptw_victim_ctr #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (adv) begin
            idx_d = (idx_q == IDX_W'(N-1)) ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx = idx_q;
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
    parameter int            AW          = 32,
    parameter int            TLB_ENTRIES = 16,
    parameter logic [AW-1:0] KBASE       = 32'h8000_0000,
    parameter int            DIR_LSB     = 22,
    parameter int            PAGE_SHIFT  = 12,
    parameter int            PTE_SHIFT   = 6,
    parameter int            VALID_BIT   = 1,
    parameter int            DIRTY_BIT   = 2,
    localparam int           IDX_W       = $clog2(TLB_ENTRIES),
    localparam int           PAIR_LSB    = PAGE_SHIFT + 1,
    localparam int           VPN_W       = AW - PAIR_LSB
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [AW-1:0]    vaddr_i,
    input  logic             is_write_i,
    input  logic [AW-1:0]    dir_base_i,
    output logic             busy_o,
    output logic             mem_req_o,
    output logic [AW-1:0]    mem_addr_o,
    input  logic             mem_ack_i,
    input  logic [AW-1:0]    mem_rdata_i,
    output logic             tlb_we_o,
    output logic [IDX_W-1:0] tlb_idx_o,
    output logic [VPN_W-1:0] tlb_vpn2_o,
    output logic [AW-1:0]    tlb_lo0_o,
    output logic [AW-1:0]    tlb_lo1_o,
    output logic             done_o,
    output logic [1:0]       result_o,
    output logic [AW-1:0]    paddr_o
);
    import ptw_pkg::*;

    typedef struct packed {
        walk_state_e   st;
        logic [AW-1:0] va;
        logic          wr;
        logic [AW-1:0] base;
        logic [AW-1:0] tbl;
        logic [AW-1:0] lo0;
        logic [AW-1:0] lo1;
        logic [1:0]    res;
        logic [AW-1:0] pa;
    } walk_regs_t;

    walk_regs_t d, q;

    logic [AW-1:0] dir_addr, even_addr, odd_addr;
    logic [1:0]    eval_res;
    logic [AW-1:0] eval_pa;

    ptw_addr_gen #(
        .AW(AW), .KBASE(KBASE), .DIR_LSB(DIR_LSB), .PAIR_LSB(PAIR_LSB)
    ) u_addr (
        .dir_base  (q.base),
        .tbl_ptr   (q.tbl),
        .va_hi     (q.va[AW-1:PAIR_LSB]),
        .dir_addr  (dir_addr),
        .even_addr (even_addr),
        .odd_addr  (odd_addr)
    );

    ptw_entry_eval #(
        .AW(AW), .PTE_SHIFT(PTE_SHIFT), .PAGE_SHIFT(PAGE_SHIFT),
        .VALID_BIT(VALID_BIT), .DIRTY_BIT(DIRTY_BIT)
    ) u_eval (
        .lo_even  (q.lo0),
        .lo_odd   (q.lo1),
        .odd_sel  (q.va[PAGE_SHIFT]),
        .page_off (q.va[PAGE_SHIFT-1:0]),
        .is_write (q.wr),
        .result   (eval_res),
        .paddr    (eval_pa)
    );

    ptw_victim_ctr #(
        .N(TLB_ENTRIES), .IDX_W(IDX_W)
    ) u_victim (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (tlb_we_o),
        .idx   (tlb_idx_o)
    );

    // Next-state computation
    always_comb begin
        d = q;
        unique case (q.st)
            S_IDLE: begin
                if (start_i) begin
                    d.va   = vaddr_i;
                    d.wr   = is_write_i;
                    d.base = dir_base_i;
                    if (dir_base_i == '0) begin
                        d.res = RES_NOMATCH;
                        d.st  = S_DONE;
                    end else begin
                        d.st  = S_DIR;
                    end
                end
            end
            S_DIR: begin
                if (mem_ack_i) begin
                    d.tbl = mem_rdata_i;
                    d.st  = S_EVEN;
                end
            end
            S_EVEN: begin
                if (mem_ack_i) begin
                    d.lo0 = mem_rdata_i >> PTE_SHIFT;
                    d.st  = S_ODD;
                end
            end
            S_ODD: begin
                if (mem_ack_i) begin
                    d.lo1 = mem_rdata_i >> PTE_SHIFT;
                    d.st  = S_WRITE;
                end
            end
            S_WRITE: begin
                d.res = eval_res;
                d.pa  = eval_pa;
                d.st  = S_DONE;
            end
            S_DONE:  d.st = S_IDLE;
            default: d.st = S_IDLE;
        endcase
    end

    // State register; S_IDLE encodes as all zeros
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // Output decode
    always_comb begin
        mem_req_o = (q.st == S_DIR) || (q.st == S_EVEN) || (q.st == S_ODD);
        unique case (q.st)
            S_DIR:   mem_addr_o = dir_addr;
            S_EVEN:  mem_addr_o = even_addr;
            S_ODD:   mem_addr_o = odd_addr;
            default: mem_addr_o = '0;
        endcase
    end

    assign busy_o     = (q.st != S_IDLE);
    assign tlb_we_o   = (q.st == S_WRITE);
    assign tlb_vpn2_o = q.va[AW-1:PAIR_LSB];
    assign tlb_lo0_o  = q.lo0;
    assign tlb_lo1_o  = q.lo1;
    assign done_o     = (q.st == S_DONE);
    assign result_o   = q.res;
    assign paddr_o    = q.pa;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk #(
    parameter int AW    = 32,
    parameter int IDX_W = 4,
    parameter int N     = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic [AW-1:0]    dir_base_i,
    input logic             busy_o,
    input logic             mem_req_o,
    input logic [AW-1:0]    mem_addr_o,
    input logic             mem_ack_i,
    input logic             tlb_we_o,
    input logic [IDX_W-1:0] tlb_idx_o,
    input logic             done_o,
    input logic [1:0]       result_o
);
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!mem_req_o && !tlb_we_o && !done_o));

    assert_zero_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o && dir_base_i == '0) |=> (done_o && result_o == 2'd3));

    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o)));

    assert_write_then_done_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_we_o |=> (done_o && !tlb_we_o));

    assert_no_overlap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_req_o && tlb_we_o));

    assert_slot_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tlb_we_o |=> (tlb_idx_o == (($past(tlb_idx_o) == IDX_W'(N-1)) ?
                                    IDX_W'(0) : IDX_W'($past(tlb_idx_o) + 1'b1))));

    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
endmodule

bind ptw_walker ptw_walker_chk #(
    .AW(AW), .IDX_W(IDX_W), .N(TLB_ENTRIES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .dir_base_i (dir_base_i),
    .busy_o     (busy_o),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .mem_ack_i  (mem_ack_i),
    .tlb_we_o   (tlb_we_o),
    .tlb_idx_o  (tlb_idx_o),
    .done_o     (done_o),
    .result_o   (result_o)
);

// File: tb/tb_ptw_walker.sv
`timescale 1ns/1ps
module tb_ptw_walker;
    localparam int          N    = 16;
    localparam logic [31:0] K    = 32'h8000_0000;
    localparam logic [31:0] DIRB = 32'h8010_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] vaddr_i = '0;
    logic        is_write_i = 1'b0;
    logic [31:0] dir_base_i = '0;
    logic        busy_o, mem_req_o, mem_ack_i, tlb_we_o, done_o;
    logic [31:0] mem_addr_o, mem_rdata_i, tlb_lo0_o, tlb_lo1_o, paddr_o;
    logic [3:0]  tlb_idx_o;
    logic [18:0] tlb_vpn2_o;
    logic [1:0]  result_o;

    always #10 clk = ~clk;

    ptw_walker #(.TLB_ENTRIES(N)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .vaddr_i(vaddr_i),
        .is_write_i(is_write_i), .dir_base_i(dir_base_i), .busy_o(busy_o),
        .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_ack_i(mem_ack_i),
        .mem_rdata_i(mem_rdata_i), .tlb_we_o(tlb_we_o), .tlb_idx_o(tlb_idx_o),
        .tlb_vpn2_o(tlb_vpn2_o), .tlb_lo0_o(tlb_lo0_o), .tlb_lo1_o(tlb_lo1_o),
        .done_o(done_o), .result_o(result_o), .paddr_o(paddr_o)
    );

    typedef struct {
        logic [1:0]  res;
        logic [31:0] pa;
        bit          we;
        logic [3:0]  idx;
        logic [31:0] lo0;
        logic [31:0] lo1;
        logic [18:0] vpn;
    } exp_t;

    logic [31:0] mem [logic [31:0]];
    exp_t        exp_q[$];
    logic [31:0] addr_q[$];
    int          n_chk = 0;
    int          n_bad = 0;
    int          lat = 0;
    int          slot = 0;
    bit          finished = 0;

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    function automatic logic [31:0] raw_pte(input logic [19:0] pfn, input bit v, input bit dty);
        return {pfn, 12'h0} | (32'(dty) << 8) | (32'(v) << 7);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic map(input logic [31:0] va, input logic [31:0] tp,
                       input logic [31:0] raw_e, input logic [31:0] raw_o);
        logic [31:0] pe;
        mem[(DIRB - K) + ((va >> 22) << 2)] = tp;
        pe = (tp - K) + (((va >> 13) & 32'h1FF) << 3);
        mem[pe]     = raw_e;
        mem[pe + 4] = raw_o;
    endtask

    // Driver: computes expectations from the requirements and launches a walk
    task automatic walk(input logic [31:0] va, input bit wr, input logic [31:0] base, input bit intrude);
        exp_t e;
        logic [31:0] tp, pe, sel;
        e.we = 0; e.pa = '0; e.idx = '0; e.lo0 = '0; e.lo1 = '0; e.vpn = va[31:13];
        if (base == 0) begin
            e.res = 2'd3;
        end else begin
            addr_q.push_back((base - K) + ((va >> 22) << 2));
            tp = rd((base - K) + ((va >> 22) << 2));
            pe = (tp - K) + (((va >> 13) & 32'h1FF) << 3);
            addr_q.push_back(pe);
            addr_q.push_back(pe + 4);
            e.lo0 = rd(pe) >> 6;
            e.lo1 = rd(pe + 4) >> 6;
            sel   = va[12] ? e.lo1 : e.lo0;
            if (!sel[1])             e.res = 2'd1;
            else if (wr && !sel[2])  e.res = 2'd2;
            else                     e.res = 2'd0;
            e.pa  = ((sel >> 6) << 12) | {20'h0, va[11:0]};
            e.we  = 1;
            e.idx = 4'(slot);
            slot  = (slot + 1) % N;
        end
        exp_q.push_back(e);
        while (busy_o) @(negedge clk);
        start_i = 1'b1; vaddr_i = va; is_write_i = wr; dir_base_i = base;
        @(negedge clk);
        if (intrude) begin
            chk(busy_o == 1'b1, "R11 busy after start", 32'(busy_o), 32'd1);
            vaddr_i = ~va; is_write_i = ~wr; dir_base_i = 32'h0;
        end else begin
            start_i = 1'b0;
        end
        @(negedge clk);
        start_i = 1'b0;
        while (busy_o) @(negedge clk);
        @(negedge clk);
    endtask

    // Memory responder: acknowledges after `lat` waiting cycles
    initial begin
        int wc;
        wc = 0;
        mem_ack_i = 1'b0;
        mem_rdata_i = '0;
        forever begin
            @(negedge clk);
            if (mem_ack_i) begin
                mem_ack_i = 1'b0;
                wc = 0;
            end else if (mem_req_o) begin
                if (wc >= lat) begin
                    if (addr_q.size() == 0) begin
                        chk(1'b0, "R2/R3/R4 unexpected read", mem_addr_o, 32'hFFFF_FFFF);
                    end else begin
                        chk(mem_addr_o == addr_q[0], "R3/R4 read address", mem_addr_o, addr_q[0]);
                        void'(addr_q.pop_front());
                    end
                    mem_rdata_i = rd(mem_addr_o);
                    mem_ack_i = 1'b1;
                end else begin
                    wc++;
                end
            end
        end
    end

    // Monitor: pops expected items as results appear
    initial begin
        int   seen;
        exp_t e;
        seen = 0;
        forever begin
            @(negedge clk);
            if (rst_n && tlb_we_o) begin
                seen++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R6 spurious write", 32'(tlb_idx_o), 32'hFFFF_FFFF);
                end else begin
                    chk(tlb_idx_o == exp_q[0].idx, "R7 slot", 32'(tlb_idx_o), 32'(exp_q[0].idx));
                    chk(tlb_lo0_o == exp_q[0].lo0, "R6 even entry", tlb_lo0_o, exp_q[0].lo0);
                    chk(tlb_lo1_o == exp_q[0].lo1, "R6 odd entry", tlb_lo1_o, exp_q[0].lo1);
                    chk(tlb_vpn2_o == exp_q[0].vpn, "R6 page pair", 32'(tlb_vpn2_o), 32'(exp_q[0].vpn));
                end
            end
            if (rst_n && done_o) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R11 extra walk finished", 32'(result_o), 32'hFFFF_FFFF);
                end else begin
                    e = exp_q.pop_front();
                    chk(result_o == e.res, "R8/R9 result", 32'(result_o), 32'(e.res));
                    if (e.res == 2'd0)
                        chk(paddr_o == e.pa, "R10 physical address", paddr_o, e.pa);
                    chk(seen == int'(e.we), "R2/R6 write count", 32'(seen), 32'(e.we));
                end
                seen = 0;
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle after reset
        chk(!busy_o && !mem_req_o && !tlb_we_o && !done_o, "R1 reset idle",
            {28'h0, busy_o, mem_req_o, tlb_we_o, done_o}, 32'h0);

        map(32'h0040_2ABC, 32'h8020_0000, raw_pte(20'h00111, 1, 1), raw_pte(20'h00222, 1, 0));
        lat = 0;
        walk(32'h0040_3ABC, 0, DIRB, 0);   // R8 odd half, R9 read of clean page -> match
        lat = 2;
        walk(32'h0040_2ABC, 1, DIRB, 0);   // R9/R10 write of dirty even page -> match
        walk(32'h0040_3ABC, 1, DIRB, 0);   // R9 write of clean odd page -> modify

        map(32'h1234_4678, 32'h8030_0000, raw_pte(20'h0ABCD, 1, 0), raw_pte(20'h0F00F, 0, 1));
        lat = 1;
        walk(32'h1234_5678, 0, DIRB, 0);   // R8 odd invalid
        walk(32'h1234_4678, 0, DIRB, 0);   // R8 even valid -> match

        walk(32'h0040_3ABC, 0, 32'h0, 0);  // R2 zero base
        walk(32'h0040_3ABC, 1, 32'h0, 1);  // R2 + R11 during the short walk
        lat = 3;
        walk(32'h0040_2ABC, 1, DIRB, 1);   // R11 ignored start during a long walk

        // R7 wrap: enough refills to pass the last slot
        for (int i = 0; i < 18; i++) begin
            logic [31:0] va;
            va = 32'h0080_0000 + (32'(i) << 13) + 32'(i * 4);
            map(va, 32'h8040_0000, raw_pte(20'(i + 16'h100), 1, i[0]), raw_pte(20'(i + 16'h200), 1, 1));
            lat = i % 4;
            walk(va, i[1], DIRB, 0);
        end

        repeat (4) @(negedge clk);
        chk(exp_q.size() == 0, "R12 all walks finished", 32'(exp_q.size()), 32'd0);
        chk(!busy_o, "R12 idle at end", 32'(busy_o), 32'd0);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule